// File: doc/BRIEF.md
# Dual-Source Clock Output Divider

This block produces one programmable square-wave clock output from one of two timing sources. Both sources arrive as single-cycle enable pulses in the system clock domain. Each pulse marks one half-period of its source: an edge of the 32768 Hz source, or an edge of the fast (roughly 4 MHz) source. An 8-bit control word turns the output on, picks the source, and sets two divider stages. A fixed-table prescaler acts only on the fast path. A power-of-two stage follows it on both paths.

The overall ratio D is the prescaler ratio times 2^N. The output toggles once every D pulses of the selected source, so each output period spans D source periods at about 50% duty. A chip with several outputs places one instance per output, each fed from its own control register.

Control fields that change while the output runs are held back until the end of the current output period, which is the high-to-low transition. This keeps runt pulses off the output pin.

Top module: `clkout_divider`

## Requirements
- R1: After reset `clk_out` is low.
- R2: While `ctrl[0]` (enable) is 0, `clk_out` is low by the cycle after the clear and stays low. On re-enable the divider restarts from zero, and the first rising edge comes after exactly D ticks of the selected source.
- R3: With `ctrl[4]`=0 (slow source), `clk_out` toggles every 2^N slow ticks, where N is `ctrl[3:1]`.
- R4: With the slow source selected, the prescaler code `ctrl[7:5]` has no effect on the ratio.
- R5: With `ctrl[4]`=1 (fast source), only fast ticks advance the divider. Prescaler codes 0 to 6 divide by 2^code.
- R6: Prescaler code 7 divides by 122, so the output toggles every 122·2^N fast ticks.
- R7: On the fast path both stages act together: each half-period of the output lasts (prescaler ratio)·2^N fast ticks.
- R8: A change to `ctrl[7:1]` made while enabled takes effect only at the next high-to-low transition of `clk_out`. Every half-period up to that transition keeps the old ratio.
- R9: While enabled, `clk_out` changes only in the cycle after a tick of the selected source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | One-cycle pulse per half-period of the 32768 Hz source |
| fast_tick | input | 1 | One-cycle pulse per half-period of the fast source |
| ctrl | input | 8 | [7:5] prescaler code, [4] source select, [3:1] exponent N, [0] enable |
| clk_out | output | 1 | Divided square-wave output |

## Verification
The hardest situation to reach is a reconfiguration that lands partway through an output period. To show the deferral, the old ratio must be seen to persist through the rest of that period and then switch cleanly. The stimulus waits for an observed edge of `clk_out` and rewrites the exponent one cycle later. It does this once during a high half and once during a low half. It then measures the following half-periods in ticks of the selected source rather than in system cycles. The two sources tick with unrelated gap patterns, so a wrongly routed or wrongly held source shows up as a count mismatch.

// File: rtl/clkout_div_pkg.sv
package clkout_div_pkg;

  typedef enum logic {
    SRC_SLOW = 1'b0,
    SRC_FAST = 1'b1
  } src_sel_e;

  localparam int DEF_PRE_CODE_W     = 3;
  localparam int DEF_POST_EXP_W     = 3;
  localparam int DEF_LAST_PRE_RATIO = 122;

endpackage

// File: rtl/clkout_prescaler.sv
module clkout_prescaler #(
  parameter int CODE_W     = 3,
  parameter int LAST_RATIO = 122
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              bypass,
  input  logic              tick_in,
  input  logic [CODE_W-1:0] code,
  output logic              tick_out
);
  localparam int TOP_CODE  = (1 << CODE_W) - 1;
  localparam int POW_MAX   = 1 << (TOP_CODE - 1);
  localparam int MAX_RATIO = (LAST_RATIO > POW_MAX) ? LAST_RATIO : POW_MAX;
  localparam int CNT_W     = (MAX_RATIO > 1) ? $clog2(MAX_RATIO) : 1;

  logic [CNT_W-1:0] limit_tab [TOP_CODE+1];
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic             at_end;

  // terminal count per code: powers of two, top code uses the irregular ratio
  for (genvar g = 0; g <= TOP_CODE; g++) begin : g_limit
    if (g == TOP_CODE) begin : g_last
      assign limit_tab[g] = CNT_W'(LAST_RATIO - 1);
    end else begin : g_pow
      assign limit_tab[g] = CNT_W'((1 << g) - 1);
    end
  end

  assign limit    = limit_tab[code];
  assign at_end   = (cnt_q == limit);
  assign tick_out = tick_in & (bypass | at_end);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr || bypass) begin
      cnt_q <= '0;
    end else if (tick_in) begin
      cnt_q <= at_end ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/clkout_pow2_div.sv
module clkout_pow2_div #(
  parameter int EXP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick_in,
  input  logic [EXP_W-1:0] exp_sel,
  output logic             tick_out
);
  localparam int CNT_W = (1 << EXP_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mask;
  logic             at_end;

  // mask of N low ones is the terminal count for division by 2^N
  for (genvar b = 0; b < CNT_W; b++) begin : g_mask
    assign mask[b] = (exp_sel > EXP_W'(b));
  end

  assign at_end   = (cnt_q == mask);
  assign tick_out = tick_in & at_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (tick_in) begin
      cnt_q <= at_end ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/clkout_divider.sv
module clkout_divider
  import clkout_div_pkg::*;
#(
  parameter int  PRE_CODE_W     = DEF_PRE_CODE_W,
  parameter int  POST_EXP_W     = DEF_POST_EXP_W,
  parameter int  LAST_PRE_RATIO = DEF_LAST_PRE_RATIO,
  localparam int CTRL_W         = PRE_CODE_W + POST_EXP_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              fast_tick,
  input  logic [CTRL_W-1:0] ctrl,
  output logic              clk_out
);
  localparam int SEL_BIT  = POST_EXP_W + 1;
  localparam int CODE_LSB = POST_EXP_W + 2;
  localparam int ACT_W    = PRE_CODE_W + POST_EXP_W + 1;

  logic                  en;
  logic [POST_EXP_W-1:0] exp_in;
  src_sel_e              sel_in;
  logic [PRE_CODE_W-1:0] code_in;

  logic [POST_EXP_W-1:0] act_exp;
  src_sel_e              act_sel;
  logic [PRE_CODE_W-1:0] act_code;
  logic                  run_q;
  logic                  out_q;

  logic [POST_EXP_W-1:0] eff_exp;
  src_sel_e              eff_sel;
  logic [PRE_CODE_W-1:0] eff_code;
  logic                  src_tick;
  logic                  pre_tick;
  logic                  post_tick;
  logic                  load_act;
  logic [ACT_W-1:0]      act_cfg;

  assign en      = ctrl[0];
  assign exp_in  = ctrl[POST_EXP_W:1];
  assign sel_in  = src_sel_e'(ctrl[SEL_BIT]);
  assign code_in = ctrl[CTRL_W-1:CODE_LSB];

  // while idle the fields pass straight through; once running the held copy rules
  assign eff_exp  = run_q ? act_exp  : exp_in;
  assign eff_sel  = run_q ? act_sel  : sel_in;
  assign eff_code = run_q ? act_code : code_in;

  assign src_tick = (eff_sel == SRC_FAST) ? fast_tick : slow_tick;

  clkout_prescaler #(
    .CODE_W     (PRE_CODE_W),
    .LAST_RATIO (LAST_PRE_RATIO)
  ) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (!en),
    .bypass   (eff_sel == SRC_SLOW),
    .tick_in  (src_tick),
    .code     (eff_code),
    .tick_out (pre_tick)
  );

  clkout_pow2_div #(
    .EXP_W (POST_EXP_W)
  ) u_post (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (!en),
    .tick_in  (pre_tick),
    .exp_sel  (eff_exp),
    .tick_out (post_tick)
  );

  // period boundary: the high half ends; both counters wrap to zero here
  assign load_act = !run_q || (en && post_tick && out_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_exp  <= '0;
      act_sel  <= SRC_SLOW;
      act_code <= '0;
      run_q    <= 1'b0;
      out_q    <= 1'b0;
    end else begin
      run_q <= en;
      if (load_act) begin
        act_exp  <= exp_in;
        act_sel  <= sel_in;
        act_code <= code_in;
      end
      if (!en) begin
        out_q <= 1'b0;
      end else if (post_tick) begin
        out_q <= ~out_q;
      end
    end
  end

  assign act_cfg = {act_code, act_sel, act_exp};
  assign clk_out = out_q;

endmodule

// File: rtl/clkout_divider_chk.sv
module clkout_divider_chk #(
  parameter int ACT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             clk_out,
  input logic             src_tick,
  input logic             post_tick,
  input logic             run_q,
  input logic [ACT_W-1:0] act_cfg
);

  a_r1_low_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !clk_out);

  a_r2_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !clk_out);

  a_r8_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run_q) && $past(en) && !$fell(clk_out)) |-> $stable(act_cfg));

  a_r7_stage_from_source: assert property (@(posedge clk) disable iff (!rst_n)
    post_tick |-> src_tick);

  a_r9_edge_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_out != $past(clk_out)) |-> ($past(src_tick) || !$past(en)));

endmodule

bind clkout_divider clkout_divider_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (ctrl[0]),
  .clk_out   (clk_out),
  .src_tick  (src_tick),
  .post_tick (post_tick),
  .run_q     (run_q),
  .act_cfg   (act_cfg)
);

// File: tb/clkout_divider_bench.sv
module clkout_divider_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slow_tick = 1'b0;
  logic       fast_tick = 1'b0;
  logic [7:0] ctrl = 8'h00;
  logic       clk_out;

  int checks = 0;
  int fails = 0;
  int phase = 0;
  int cnt_fast = 0;
  int cnt_slow = 0;
  int last_fast = 0;
  int last_slow = 0;
  int chg = 0;
  logic prev_out = 1'b0, prev_en = 1'b0, prev_sel = 1'b0, prev_ft = 1'b0, prev_st = 1'b0;

  always #4 clk = ~clk;

  clkout_divider u_clkout_divider (
    .clk       (clk),
    .rst_n     (rst_n),
    .slow_tick (slow_tick),
    .fast_tick (fast_tick),
    .ctrl      (ctrl),
    .clk_out   (clk_out)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor and tick source: counts ticks per half-period, drives ticks at negedge
  always @(negedge clk) begin
    if (rst_n && (clk_out !== prev_out)) begin
      last_fast = cnt_fast;
      last_slow = cnt_slow;
      cnt_fast  = 0;
      cnt_slow  = 0;
      if (prev_en) check("R9 edge follows selected tick", int'(prev_sel ? prev_ft : prev_st), 1);
      else         check("R9 edge while disabled must fall", int'(clk_out), 0);
      chg++;
    end
    prev_out  = clk_out;
    prev_en   = ctrl[0];
    prev_sel  = ctrl[4];
    phase++;
    fast_tick = (phase % 4) != 3;
    slow_tick = (phase % 5) == 0;
    if (fast_tick) cnt_fast++;
    if (slow_tick) cnt_slow++;
    prev_ft = fast_tick;
    prev_st = slow_tick;
  end

  function automatic int pre_ratio(input int code);
    return (code == 7) ? 122 : (1 << code);
  endfunction

  function automatic int half_len(input bit fast, input int code, input int n);
    return (fast ? pre_ratio(code) : 1) << n;
  endfunction

  task automatic wr(input logic [7:0] v, input bit zero);
    @(posedge clk);
    #1;
    ctrl = v;
    if (zero) begin
      cnt_fast = 0;
      cnt_slow = 0;
    end
  endtask

  task automatic wait_chg();
    int t = chg;
    wait (chg > t);
  endtask

  function automatic logic [7:0] pack(input int code, input bit fast, input int n, input bit en);
    return {3'(code), fast, 3'(n), en};
  endfunction

  task automatic run_rate(input string req, input bit fast, input int code, input int n);
    int exp_h = half_len(fast, code, n);
    wr(8'h00, 1'b0);
    repeat (3) @(posedge clk);
    wr(pack(code, fast, n, 1'b1), 1'b1);
    for (int k = 0; k < 3; k++) begin
      wait_chg();
      check(req, fast ? last_fast : last_slow, exp_h);
    end
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    check("R1 low during reset", int'(clk_out), 0);
  endtask

  task automatic t_after_reset();
    @(negedge clk);
    check("R1 low after reset", int'(clk_out), 0);
  endtask

  task automatic t_slow();
    run_rate("R3 slow N=0", 1'b0, 0, 0);
    run_rate("R3 slow N=2", 1'b0, 0, 2);
    run_rate("R3 slow N=5", 1'b0, 0, 5);
  endtask

  task automatic t_slow_ignores_pre();
    run_rate("R4 slow code7 N=1", 1'b0, 7, 1);
    run_rate("R4 slow code5 N=0", 1'b0, 5, 0);
  endtask

  task automatic t_fast();
    run_rate("R5 fast code0", 1'b1, 0, 0);
    run_rate("R5 fast code3", 1'b1, 3, 0);
    run_rate("R5 fast code6", 1'b1, 6, 0);
  endtask

  task automatic t_last_code();
    run_rate("R6 code7 N=0", 1'b1, 7, 0);
    run_rate("R6 code7 N=2", 1'b1, 7, 2);
  endtask

  task automatic t_combo();
    run_rate("R7 code2 N=3", 1'b1, 2, 3);
    run_rate("R7 code1 N=7", 1'b1, 1, 7);
  endtask

  task automatic t_reconfig();
    wr(8'h00, 1'b0);
    repeat (3) @(posedge clk);
    wr(pack(0, 1'b0, 1, 1'b1), 1'b1);
    wait_chg();                              // rise, now in high half
    check("R8 start high", int'(clk_out), 1);
    wr(pack(0, 1'b0, 3, 1'b1), 1'b0);        // change during high half
    wait_chg();
    check("R8 high half keeps old ratio", last_slow, 2);
    wait_chg();
    check("R8 new ratio after fall", last_slow, 8);
    wait_chg();                              // fall, now in low half
    check("R8 in low half", int'(clk_out), 0);
    wr(pack(0, 1'b0, 0, 1'b1), 1'b0);        // change during low half
    wait_chg();
    check("R8 low half keeps old ratio", last_slow, 8);
    wait_chg();
    check("R8 high half still old", last_slow, 8);
    wait_chg();
    check("R8 new ratio after boundary", last_slow, 1);
  endtask

  task automatic t_disable();
    int bad = 0;
    wr(8'h00, 1'b0);
    repeat (3) @(posedge clk);
    wr(pack(0, 1'b0, 2, 1'b1), 1'b1);
    wait_chg();
    check("R2 first rise after D ticks", last_slow, 4);
    wr(pack(0, 1'b0, 2, 1'b0), 1'b0);
    @(posedge clk);
    @(negedge clk);
    check("R2 low after disable", int'(clk_out), 0);
    ctrl = pack(7, 1'b1, 7, 1'b0);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (clk_out !== 1'b0) bad++;
    end
    check("R2 stays low while disabled", bad, 0);
    wr(pack(3, 1'b1, 1, 1'b1), 1'b1);
    wait_chg();
    check("R2 restart from zero", last_fast, 16);
  endtask

  initial begin
    t_reset();
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    t_after_reset();
    t_slow();
    t_slow_ignores_pre();
    t_fast();
    t_last_code();
    t_combo();
    t_reconfig();
    t_disable();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule